// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is the logic core of a small programmable logic device. A configurable AND plane forms 64 product terms from 16 array signals, each offered in true and inverted form, so the plane has 32 columns. A fixed OR plane then combines the product terms in groups of eight, one group per output macrocell. A register bank holds one 32-bit connection row and one use bit for each product term. The bank is loaded one row at a time through a write port.

Evaluation is purely combinational from `in_sig` and the stored rows to the term, sum and output-enable outputs. A term whose row connects no column is HIGH. A term that connects both polarities of one signal is LOW. A term whose use bit is clear is forced LOW, so it adds nothing to its group's sum.

Each group can divert its first term away from the OR gate and use it as an output-enable term for that macrocell. The surrounding logic does this for combinatorial I/O modes. A sticky lock flag blocks readback of the stored rows. Writes are still accepted while the flag is set.

Top module: `sop_array`

## Requirements
- R1: After synchronous reset every row is cleared and its use bit is clear, and the lock flag is clear. Therefore `term_out`, `sum_out`, `oe_term`, `rd_fuses`, `rd_term_en` and `locked` are all 0.
- R2: Row bit 2i connects the true form of `in_sig[i]`, and bit 2i+1 connects its complement; a bit value of 1 means connected. An enabled term is the AND of all its connected columns.
- R3: An enabled term with no connected column evaluates HIGH.
- R4: An enabled term that connects both bit 2i and bit 2i+1 evaluates LOW for every input value.
- R5: A term whose use bit is 0 drives its `term_out` bit LOW and does not contribute to its group's sum.
- R6: With `oe_split[k]`=0, `sum_out[k]` is the OR of terms 8k to 8k+7, and `oe_term[k]` is 0.
- R7: With `oe_split[k]`=1, `oe_term[k]` equals term 8k, and `sum_out[k]` is the OR of terms 8k+1 to 8k+7 only.
- R8: A write (`wr_en`=1) stores `wr_fuses` and `wr_term_en` into row `wr_addr` at the rising clock edge. The outputs reflect the new row from that edge on, with no further delay.
- R9: While unlocked, `rd_fuses` and `rd_term_en` return the stored row and use bit for `rd_addr`, combinationally.
- R10: A `lock_set` pulse sets `locked` at the next edge. The flag stays set until reset, and while it is set the readback outputs are 0. Writes stay effective while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sig | input | 16 | Array signals (dedicated inputs and feedbacks) |
| oe_split | input | 8 | Per group: divert first term to output enable |
| wr_en | input | 1 | Row write strobe |
| wr_addr | input | 6 | Row index to write |
| wr_fuses | input | 32 | Column connections for the row |
| wr_term_en | input | 1 | Use bit for the row |
| lock_set | input | 1 | Set the sticky readback lock |
| rd_addr | input | 6 | Row index to read back |
| rd_fuses | output | 32 | Read-back row, 0 when locked |
| rd_term_en | output | 1 | Read-back use bit, 0 when locked |
| locked | output | 1 | Lock flag |
| term_out | output | 64 | Product-term results |
| sum_out | output | 8 | OR sum per group |
| oe_term | output | 8 | Output-enable term per group |

## Verification
Term, sum, output-enable and readback results depend only on the inputs in the same cycle. The bench therefore drives `in_sig`, `oe_split` and `rd_addr` on a falling edge and samples 2 ns later, before the next rising edge. A row write or `lock_set` takes effect at the rising edge after it is driven, which is zero cycles of latency beyond the register. The bench holds the strobe for one full cycle and makes every dependent check from the following falling edge on. Expected values come from a model of the rows the bench itself has written.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int SIG_COUNT    = 16;
    localparam int GROUP_COUNT  = 8;
    localparam int GROUP_TERMS  = 8;

    // Result of one signal's column pair against one product row.
    typedef enum logic [1:0] {
        PAIR_OPEN  = 2'b00,
        PAIR_TRUE  = 2'b01,
        PAIR_COMP  = 2'b10,
        PAIR_BOTH  = 2'b11
    } pair_use_e;

    // Returns 1 when this column pair forces the product term low.
    function automatic logic pair_kills(input logic [1:0] pair_fuse, input logic sig);
        pair_use_e use_k;
        use_k = pair_use_e'(pair_fuse);
        case (use_k)
            PAIR_OPEN: return 1'b0;
            PAIR_TRUE: return ~sig;
            PAIR_COMP: return sig;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/sop_fuse_bank.sv
module sop_fuse_bank #(
    parameter int ROWS = 64,
    parameter int COLS = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(ROWS)-1:0]  wr_addr,
    input  logic [COLS-1:0]          wr_fuses,
    input  logic                     wr_term_en,
    input  logic                     lock_set,
    input  logic [$clog2(ROWS)-1:0]  rd_addr,
    output logic [COLS-1:0]          rd_fuses,
    output logic                     rd_term_en,
    output logic                     locked,
    output logic [ROWS*COLS-1:0]     fuse_flat,
    output logic [ROWS-1:0]          term_en
);

    logic [COLS-1:0] fuse_mem [ROWS];
    logic [ROWS-1:0] use_bits;
    logic            lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) begin
                fuse_mem[r] <= '0;
            end
            use_bits <= '0;
            lock_q   <= 1'b0;
        end else begin
            if (wr_en) begin
                fuse_mem[wr_addr] <= wr_fuses;
                use_bits[wr_addr] <= wr_term_en;
            end
            if (lock_set) begin
                lock_q <= 1'b1;
            end
        end
    end

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_flat
            assign fuse_flat[r*COLS +: COLS] = fuse_mem[r];
        end
    endgenerate

    assign term_en    = use_bits;
    assign locked     = lock_q;
    assign rd_fuses   = lock_q ? '0 : fuse_mem[rd_addr];
    assign rd_term_en = lock_q ? 1'b0 : use_bits[rd_addr];

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
    import sop_pkg::*;
#(
    parameter int NSIG = 16,
    parameter int ROWS = 64,
    localparam int COLS = 2 * NSIG
) (
    input  logic [NSIG-1:0]       in_sig,
    input  logic [ROWS*COLS-1:0]  fuse_flat,
    input  logic [ROWS-1:0]       term_en,
    output logic [ROWS-1:0]       term_out
);

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            logic [NSIG-1:0] kill;
            for (genvar i = 0; i < NSIG; i++) begin : g_sig
                assign kill[i] = pair_kills(fuse_flat[r*COLS + 2*i +: 2], in_sig[i]);
            end
            assign term_out[r] = term_en[r] & ~(|kill);
        end
    endgenerate

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int GROUPS = 8,
    parameter int TPG    = 8,
    localparam int ROWS  = GROUPS * TPG
) (
    input  logic [ROWS-1:0]   term_in,
    input  logic [GROUPS-1:0] oe_split,
    output logic [GROUPS-1:0] sum_out,
    output logic [GROUPS-1:0] oe_term
);

    localparam logic [TPG-1:0] KEEP_ALL   = '1;
    localparam logic [TPG-1:0] SKIP_FIRST = KEEP_ALL << 1;

    generate
        for (genvar k = 0; k < GROUPS; k++) begin : g_grp
            logic [TPG-1:0] grp_terms;
            logic [TPG-1:0] grp_mask;
            assign grp_terms  = term_in[k*TPG +: TPG];
            assign grp_mask   = oe_split[k] ? SKIP_FIRST : KEEP_ALL;
            assign sum_out[k] = |(grp_terms & grp_mask);
            assign oe_term[k] = oe_split[k] & grp_terms[0];
        end
    endgenerate

endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_pkg::*;
#(
    parameter int NUM_SIG = SIG_COUNT,
    parameter int NUM_MC  = GROUP_COUNT,
    parameter int MC_TERMS = GROUP_TERMS,
    localparam int COLS  = 2 * NUM_SIG,
    localparam int ROWS  = NUM_MC * MC_TERMS,
    localparam int AW    = $clog2(ROWS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SIG-1:0] in_sig,
    input  logic [NUM_MC-1:0]  oe_split,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [COLS-1:0]    wr_fuses,
    input  logic               wr_term_en,
    input  logic               lock_set,
    input  logic [AW-1:0]      rd_addr,
    output logic [COLS-1:0]    rd_fuses,
    output logic               rd_term_en,
    output logic               locked,
    output logic [ROWS-1:0]    term_out,
    output logic [NUM_MC-1:0]  sum_out,
    output logic [NUM_MC-1:0]  oe_term
);

    logic [ROWS*COLS-1:0] fuse_flat;
    logic [ROWS-1:0]      term_en;

    sop_fuse_bank #(.ROWS(ROWS), .COLS(COLS)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_fuses   (wr_fuses),
        .wr_term_en (wr_term_en),
        .lock_set   (lock_set),
        .rd_addr    (rd_addr),
        .rd_fuses   (rd_fuses),
        .rd_term_en (rd_term_en),
        .locked     (locked),
        .fuse_flat  (fuse_flat),
        .term_en    (term_en)
    );

    sop_and_plane #(.NSIG(NUM_SIG), .ROWS(ROWS)) u_and (
        .in_sig    (in_sig),
        .fuse_flat (fuse_flat),
        .term_en   (term_en),
        .term_out  (term_out)
    );

    sop_or_plane #(.GROUPS(NUM_MC), .TPG(MC_TERMS)) u_or (
        .term_in  (term_out),
        .oe_split (oe_split),
        .sum_out  (sum_out),
        .oe_term  (oe_term)
    );

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
    parameter int NUM_SIG  = 16,
    parameter int NUM_MC   = 8,
    parameter int MC_TERMS = 8,
    localparam int COLS = 2 * NUM_SIG,
    localparam int ROWS = NUM_MC * MC_TERMS,
    localparam int AW   = $clog2(ROWS)
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_MC-1:0] oe_split,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [COLS-1:0]   wr_fuses,
    input logic              lock_set,
    input logic [AW-1:0]     rd_addr,
    input logic [COLS-1:0]   rd_fuses,
    input logic              rd_term_en,
    input logic              locked,
    input logic [ROWS-1:0]   term_out,
    input logic [NUM_MC-1:0] sum_out,
    input logic [NUM_MC-1:0] oe_term
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (term_out == '0 && sum_out == '0 && oe_term == '0 && !locked));

    p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !locked && !lock_set) |=> (rd_addr != $past(wr_addr) || rd_fuses == $past(wr_fuses)));

    p_lock_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    p_lock_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        locked |-> (rd_fuses == '0 && !rd_term_en));

    generate
        for (genvar k = 0; k < NUM_MC; k++) begin : g_grp
            p_sum_needs_term_r6: assert property (@(posedge clk) disable iff (rst)
                sum_out[k] |-> (|term_out[k*MC_TERMS +: MC_TERMS]));
            p_sum_full_r6: assert property (@(posedge clk) disable iff (rst)
                (!oe_split[k] && |term_out[k*MC_TERMS +: MC_TERMS]) |-> sum_out[k]);
            p_oe_idle_r6: assert property (@(posedge clk) disable iff (rst)
                !oe_split[k] |-> !oe_term[k]);
            p_oe_follows_r7: assert property (@(posedge clk) disable iff (rst)
                oe_split[k] |-> (oe_term[k] == term_out[k*MC_TERMS]));
        end
    endgenerate

endmodule

bind sop_array sop_array_chk #(
    .NUM_SIG  (NUM_SIG),
    .NUM_MC   (NUM_MC),
    .MC_TERMS (MC_TERMS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .oe_split   (oe_split),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_fuses   (wr_fuses),
    .lock_set   (lock_set),
    .rd_addr    (rd_addr),
    .rd_fuses   (rd_fuses),
    .rd_term_en (rd_term_en),
    .locked     (locked),
    .term_out   (term_out),
    .sum_out    (sum_out),
    .oe_term    (oe_term)
);

// File: tb/test_sop_array.sv
module test_sop_array;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] in_sig = '0;
    logic [7:0]  oe_split = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_fuses = '0;
    logic        wr_term_en = 1'b0;
    logic        lock_set = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_fuses;
    logic        rd_term_en;
    logic        locked;
    logic [63:0] term_out;
    logic [7:0]  sum_out;
    logic [7:0]  oe_term;

    sop_array i_sop_array (
        .clk(clk), .rst(rst), .in_sig(in_sig), .oe_split(oe_split),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_fuses(wr_fuses),
        .wr_term_en(wr_term_en), .lock_set(lock_set), .rd_addr(rd_addr),
        .rd_fuses(rd_fuses), .rd_term_en(rd_term_en), .locked(locked),
        .term_out(term_out), .sum_out(sum_out), .oe_term(oe_term)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Bench's own record of what it has written.
    logic [31:0] m_fuse [64];
    logic        m_en   [64];

    typedef struct {
        string       tag;
        logic [63:0] terms;
        logic [7:0]  sums;
        logic [7:0]  oes;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic ref_term(int r, logic [15:0] s);
        if (!m_en[r]) return 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (m_fuse[r][2*i]   && !s[i]) return 1'b0;
            if (m_fuse[r][2*i+1] &&  s[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    // Driver: applies inputs on a falling edge and queues the expected result.
    task automatic evaluate(string tag, logic [15:0] s, logic [7:0] split);
        exp_t e;
        @(negedge clk);
        in_sig   = s;
        oe_split = split;
        e.tag = tag;
        for (int r = 0; r < 64; r++) e.terms[r] = ref_term(r, s);
        for (int k = 0; k < 8; k++) begin
            logic acc;
            acc = 1'b0;
            for (int j = 0; j < 8; j++) begin
                if (!(split[k] && j == 0)) acc = acc | e.terms[8*k+j];
            end
            e.sums[k] = acc;
            e.oes[k]  = split[k] ? e.terms[8*k] : 1'b0;
        end
        exp_q.push_back(e);
        -> sample_ev;
    endtask

    // Monitor: pops and compares 2 ns after the inputs change.
    initial begin
        forever begin
            exp_t e;
            @(sample_ev);
            #2;
            e = exp_q.pop_front();
            check({e.tag, " term_out"}, term_out, e.terms);
            check({e.tag, " sum_out"}, {56'd0, sum_out}, {56'd0, e.sums});
            check({e.tag, " oe_term"}, {56'd0, oe_term}, {56'd0, e.oes});
        end
    end

    task automatic write_row(logic [5:0] a, logic [31:0] f, logic en);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_fuses = f; wr_term_en = en;
        @(negedge clk);
        wr_en = 1'b0;
        m_fuse[a] = f;
        m_en[a]   = en;
    endtask

    task automatic readback(string tag, logic [5:0] a, logic [31:0] ef, logic ee);
        @(negedge clk);
        rd_addr = a;
        #2;
        check({tag, " rd_fuses"}, {32'd0, rd_fuses}, {32'd0, ef});
        check({tag, " rd_term_en"}, {63'd0, rd_term_en}, {63'd0, ee});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < 64; r++) begin
            m_fuse[r] = '0;
            m_en[r]   = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: cleared state after reset
        evaluate("R1 reset", 16'hFFFF, 8'h00);
        readback("R1 reset", 6'd5, 32'd0, 1'b0);
        @(negedge clk);
        check("R1 locked", {63'd0, locked}, 64'd0);

        // R3/R8: empty enabled row 0 goes HIGH right after its write
        write_row(6'd0, 32'h0, 1'b1);
        evaluate("R3 empty row high", 16'h0000, 8'h00);
        evaluate("R3 R8 empty row other input", 16'hA5A5, 8'h00);

        // R2: row 1 = sig0 true AND sig1 complement (bits 0 and 3)
        write_row(6'd1, 32'h0000_0009, 1'b1);
        evaluate("R2 pattern 01", 16'h0001, 8'h00);
        evaluate("R2 pattern 11", 16'h0003, 8'h00);
        evaluate("R2 pattern 00", 16'h0000, 8'h00);

        // R4: row 2 connects both forms of sig2 (bits 4 and 5)
        write_row(6'd2, 32'h0000_0030, 1'b1);
        evaluate("R4 contradiction sig2=0", 16'h0000, 8'h00);
        evaluate("R4 contradiction sig2=1", 16'h0004, 8'h00);

        // R5: row 9 empty but unused, group 1 sum stays low
        write_row(6'd9, 32'h0, 1'b0);
        evaluate("R5 unused row", 16'h1234, 8'h00);

        // R7: divert row 0 of group 0; sum follows row 1 only
        evaluate("R7 split row1 low", 16'h0000, 8'h01);
        evaluate("R7 split row1 high", 16'h0001, 8'h01);

        // R7/R6: group 7 with row 56 empty and row 63 = sig15 true
        write_row(6'd56, 32'h0, 1'b1);
        write_row(6'd63, 32'h4000_0000, 1'b1);
        evaluate("R7 g7 split sig15=0", 16'h0000, 8'h80);
        evaluate("R7 g7 split sig15=1", 16'h8000, 8'h80);
        evaluate("R6 g7 full sig15=0", 16'h0000, 8'h00);

        // R9: readback while unlocked
        readback("R9 row1", 6'd1, 32'h0000_0009, 1'b1);
        readback("R9 row9", 6'd9, 32'h0, 1'b0);

        // Mixed patterns over all groups
        for (int n = 0; n < 24; n++) begin
            logic [15:0] v;
            logic [7:0]  sp;
            v  = 16'($urandom());
            sp = 8'($urandom());
            evaluate("R2 R6 R7 sweep", v, sp);
        end

        // R10: lock, readback blocked, writes still work
        @(negedge clk);
        lock_set = 1'b1;
        @(negedge clk);
        lock_set = 1'b0;
        check("R10 locked set", {63'd0, locked}, 64'd1);
        readback("R10 blocked row1", 6'd1, 32'd0, 1'b0);
        write_row(6'd3, 32'h0000_0004, 1'b1);
        evaluate("R10 R8 write while locked", 16'h0002, 8'h00);
        evaluate("R10 write while locked sig1=0", 16'h0000, 8'h01);
        readback("R10 blocked row3", 6'd3, 32'd0, 1'b0);
        repeat (3) @(negedge clk);
        check("R10 still locked", {63'd0, locked}, 64'd1);

        // R1: reset clears rows and lock again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < 64; r++) begin
            m_fuse[r] = '0;
            m_en[r]   = 1'b0;
        end
        evaluate("R1 second reset", 16'h0000, 8'hFF);
        readback("R1 second reset", 6'd0, 32'd0, 1'b0);
        check("R1 lock cleared", {63'd0, locked}, 64'd0);

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule